// File: doc/BRIEF.md
# Banked Memory Map Decoder

This block sits beside an 8-bit processor with a 64 KiB address space and turns each access into a single chip select. It owns a small on-chip I/O port made of a direction register and a data register. The layout of the upper address space follows the port's effective value, which is the inverted direction register ORed with the data register. Depending on that value, three ROM windows and an I/O page are laid over the RAM. The port only has an effect through its low three bits.

Inside the I/O page, address bits [11:8] pick the video, sound, colour RAM, timer or expansion target. A local offset of the right width goes out with the select. For a few reads the block supplies the data itself:

- the port registers;
- colour RAM with its high nibble filled in;
- the open bus area;
- an identification area with a self-toggling byte.

Writes never reach a ROM. They land in the RAM underneath instead.

Top module: `mem_bank_decoder`

## Requirements
- R1: After reset both port registers are 0, so the effective port value is 8'hFF; a read of address 0 returns 8'h00 and a read of address 1 returns 8'h17.
- R2: A write to address 0 loads the direction register and a write to address 1 loads the data register. Reading address 0 returns the direction register. Reading address 1 returns (dir & data) | (~dir & 8'h17), with `loc_valid` high and no chip select.
- R3: A write to address 0 or 1 asserts `sel_ram` with `ram_wdata` equal to `vbus_byte`.
- R4: Reads in 16'hA000-16'hBFFF select the BASIC ROM (`sel_basic`) only when port bits [1:0] are both 1; otherwise they select RAM.
- R5: Reads in 16'hE000-16'hFFFF select the kernel ROM (`sel_krom`) when port bit 1 is 1; otherwise they select RAM.
- R6: Reads in 16'hD000-16'hDFFF behave as follows. When port bits [1:0] are not both 0, they go to the I/O page if port bit 2 is 1, and to character ROM (`sel_chr`) if port bit 2 is 0. When both bits are 0, they select RAM.
- R7: In the I/O page, address bits [11:8] pick the target and `dev_addr` carries the offset:
  - 0-3 video, offset addr[5:0];
  - 4-7 sound, offset addr[4:0];
  - 8-B colour RAM, offset addr[9:0];
  - C timer 1 and D timer 2, offset addr[3:0];
  - 16'hDF00-16'hDF0F expansion, offset addr[3:0].
- R8: A colour RAM read returns {vbus_byte[7:4], color_q} on `loc_rdata`. A colour RAM write puts wdata[3:0] on `color_wdata`.
- R9: In the I/O page, reads of 16'hDE00-16'hDF9F outside the expansion window return `vbus_byte`. Reads of 16'hDFA0-16'hDFFE return 8'h00. Writes outside the expansion window in 16'hDE00-16'hDFFF select nothing.
- R10: Each read of 16'hDFFF while the I/O page is mapped returns the bitwise inverse of the previous such read, starting at 8'hAA after reset.
- R11: Writes below 16'hD000, at or above 16'hE000, and to 16'hD000-16'hDFFF when the I/O page is not mapped all select RAM. A write to 16'hFF00 also raises `exp_trig` in the same cycle.
- R12: When neither `rd` nor `wr` is high, every select, `loc_valid` and `exp_trig` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 16 | Access address |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| vbus_byte | input | 8 | Last byte seen on the video bus |
| color_q | input | 4 | Stored colour RAM nibble at the addressed cell |
| sel_ram | output | 1 | RAM select |
| sel_basic | output | 1 | BASIC ROM select |
| sel_krom | output | 1 | Kernel ROM select |
| sel_chr | output | 1 | Character ROM select |
| sel_color | output | 1 | Colour RAM select |
| sel_video | output | 1 | Video chip select |
| sel_sound | output | 1 | Sound chip select |
| sel_tmr1 | output | 1 | Timer chip 1 select |
| sel_tmr2 | output | 1 | Timer chip 2 select |
| sel_exp | output | 1 | Expansion register select |
| dev_addr | output | 10 | Local offset for the selected I/O device |
| ram_wdata | output | 8 | Data to write into RAM |
| color_wdata | output | 4 | Data to write into colour RAM |
| loc_valid | output | 1 | Read data is supplied by this block |
| loc_rdata | output | 8 | Locally supplied read data |
| exp_trig | output | 1 | Expansion trigger pulse |

## Verification
On every cycle, the assertions check a set of local properties:
- all selects are quiet when idle, and at most one select is active at a time;
- port writes carry the video-bus byte to RAM;
- the trigger appears only on RAM writes;
- a port register takes the written value on the next cycle;
- the identification byte inverts after each read of its address.

The scoreboard scenarios cover what depends on the map as a whole. They walk the effective port value through all four low-bit layouts and confirm which ROM, I/O page or RAM answers in each region. They also check the merged colour nibble, the open-bus and identification reads, and the AA/55 sequence seen from outside.

// File: rtl/mem_bank_decoder.sv
module mem_bank_decoder #(
  parameter logic [7:0] ID_SEED  = 8'h55,
  parameter logic [7:0] PORT_PULL = 8'h17
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] addr,
  input  logic        rd,
  input  logic        wr,
  input  logic [7:0]  wdata,
  input  logic [7:0]  vbus_byte,
  input  logic [3:0]  color_q,
  output logic        sel_ram,
  output logic        sel_basic,
  output logic        sel_krom,
  output logic        sel_chr,
  output logic        sel_color,
  output logic        sel_video,
  output logic        sel_sound,
  output logic        sel_tmr1,
  output logic        sel_tmr2,
  output logic        sel_exp,
  output logic [9:0]  dev_addr,
  output logic [7:0]  ram_wdata,
  output logic [3:0]  color_wdata,
  output logic        loc_valid,
  output logic [7:0]  loc_rdata,
  output logic        exp_trig
);

  logic [7:0] dir_q, dat_q, id_q;

  wire [7:0] pv       = ~dir_q | dat_q;
  wire       lo_any   = |pv[1:0];
  wire       basic_in = &pv[1:0];
  wire       krom_in  = pv[1];
  wire       io_in    = lo_any & pv[2];
  wire       chr_in   = lo_any & ~pv[2];

  wire [3:0] hi       = addr[15:12];
  wire [3:0] pg       = addr[11:8];
  wire       is_port  = (addr[15:1] == 15'd0);
  wire       io_hit   = (hi == 4'hD) & io_in;
  wire       exp_win  = (addr[15:4] == 12'hDF0);
  wire       id_tog   = rd & io_hit & (addr == 16'hDFFF);

  assign ram_wdata   = is_port ? vbus_byte : wdata;
  assign color_wdata = wdata[3:0];
  assign exp_trig    = wr & (addr == 16'hFF00);

  always_comb begin
    case (pg)
      4'h0, 4'h1, 4'h2, 4'h3: dev_addr = {4'd0, addr[5:0]};
      4'h4, 4'h5, 4'h6, 4'h7: dev_addr = {5'd0, addr[4:0]};
      4'h8, 4'h9, 4'hA, 4'hB: dev_addr = addr[9:0];
      default:                dev_addr = {6'd0, addr[3:0]};
    endcase
  end

  always_comb begin
    sel_ram = 1'b0; sel_basic = 1'b0; sel_krom = 1'b0; sel_chr = 1'b0;
    sel_color = 1'b0; sel_video = 1'b0; sel_sound = 1'b0;
    sel_tmr1 = 1'b0; sel_tmr2 = 1'b0; sel_exp = 1'b0;
    loc_valid = 1'b0; loc_rdata = 8'h00;
    if (wr) begin
      if (io_hit) begin
        case (pg)
          4'h0, 4'h1, 4'h2, 4'h3: sel_video = 1'b1;
          4'h4, 4'h5, 4'h6, 4'h7: sel_sound = 1'b1;
          4'h8, 4'h9, 4'hA, 4'hB: sel_color = 1'b1;
          4'hC:                   sel_tmr1  = 1'b1;
          4'hD:                   sel_tmr2  = 1'b1;
          default:                sel_exp   = exp_win;
        endcase
      end else begin
        sel_ram = 1'b1;
      end
    end else if (rd) begin
      if (is_port) begin
        loc_valid = 1'b1;
        loc_rdata = addr[0] ? ((dir_q & dat_q) | (~dir_q & PORT_PULL)) : dir_q;
      end else begin
        case (hi)
          4'hA, 4'hB: if (basic_in) sel_basic = 1'b1; else sel_ram = 1'b1;
          4'hE, 4'hF: if (krom_in) sel_krom = 1'b1; else sel_ram = 1'b1;
          4'hD: begin
            if (io_in) begin
              case (pg)
                4'h0, 4'h1, 4'h2, 4'h3: sel_video = 1'b1;
                4'h4, 4'h5, 4'h6, 4'h7: sel_sound = 1'b1;
                4'h8, 4'h9, 4'hA, 4'hB: begin
                  sel_color = 1'b1;
                  loc_valid = 1'b1;
                  loc_rdata = {vbus_byte[7:4], color_q};
                end
                4'hC: sel_tmr1 = 1'b1;
                4'hD: sel_tmr2 = 1'b1;
                default: begin
                  if (exp_win) begin
                    sel_exp = 1'b1;
                  end else if (addr < 16'hDFA0) begin
                    loc_valid = 1'b1;
                    loc_rdata = vbus_byte;
                  end else begin
                    loc_valid = 1'b1;
                    loc_rdata = (addr == 16'hDFFF) ? ~id_q : 8'h00;
                  end
                end
              endcase
            end else if (chr_in) begin
              sel_chr = 1'b1;
            end else begin
              sel_ram = 1'b1;
            end
          end
          default: sel_ram = 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q <= 8'h00;
      dat_q <= 8'h00;
      id_q  <= ID_SEED;
    end else begin
      if (wr && is_port) begin
        if (addr[0]) dat_q <= wdata;
        else         dir_q <= wdata;
      end
      if (id_tog) id_q <= ~id_q;
    end
  end

  wire [9:0] sel_vec = {sel_ram, sel_basic, sel_krom, sel_chr, sel_color,
                        sel_video, sel_sound, sel_tmr1, sel_tmr2, sel_exp};

  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd || wr) |-> (sel_vec == 10'd0 && !loc_valid && !exp_trig));
  a_r7_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_vec));
  a_r3_port_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr[15:1] == 15'd0) |-> (sel_ram && ram_wdata == vbus_byte));
  a_r11_trig_on_ram: assert property (@(posedge clk) disable iff (!rst_n)
    exp_trig |-> (wr && sel_ram));
  a_r2_dir_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == 16'h0000) |=> (dir_q == $past(wdata)));
  a_r10_id_flip: assert property (@(posedge clk) disable iff (!rst_n)
    id_tog |=> (id_q == ~$past(id_q)));

endmodule

// File: tb/mem_bank_decoder_tb_top.sv
module mem_bank_decoder_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic rd = 1'b0, wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] vbus_byte = 8'h3C;
  logic [3:0] color_q = 4'hA;
  logic sel_ram, sel_basic, sel_krom, sel_chr, sel_color, sel_video;
  logic sel_sound, sel_tmr1, sel_tmr2, sel_exp, loc_valid, exp_trig;
  logic [9:0] dev_addr;
  logic [7:0] ram_wdata, loc_rdata;
  logic [3:0] color_wdata;

  always #4 clk = ~clk;

  mem_bank_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd(rd), .wr(wr), .wdata(wdata),
    .vbus_byte(vbus_byte), .color_q(color_q),
    .sel_ram(sel_ram), .sel_basic(sel_basic), .sel_krom(sel_krom), .sel_chr(sel_chr),
    .sel_color(sel_color), .sel_video(sel_video), .sel_sound(sel_sound),
    .sel_tmr1(sel_tmr1), .sel_tmr2(sel_tmr2), .sel_exp(sel_exp),
    .dev_addr(dev_addr), .ram_wdata(ram_wdata), .color_wdata(color_wdata),
    .loc_valid(loc_valid), .loc_rdata(loc_rdata), .exp_trig(exp_trig));

  typedef struct {
    logic [9:0] sel;
    logic       lv;
    logic [7:0] ld;
    logic       chk_da;
    logic [9:0] da;
    logic       chk_rw;
    logic [7:0] rw;
    logic       chk_cw;
    logic [3:0] cw;
    logic       trig;
    string      req;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0;
  logic [7:0] m_dir = 8'h00, m_dat = 8'h00, m_id = 8'h55;

  localparam int S_RAM = 9, S_BAS = 8, S_KRM = 7, S_CHR = 6, S_COL = 5;
  localparam int S_VID = 4, S_SND = 3, S_T1 = 2, S_T2 = 1, S_EXP = 0;

  task automatic cmp(input string req, input string what, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      cmp(e.req, "sel", {sel_ram, sel_basic, sel_krom, sel_chr, sel_color,
                         sel_video, sel_sound, sel_tmr1, sel_tmr2, sel_exp}, e.sel);
      cmp(e.req, "loc_valid", loc_valid, e.lv);
      if (e.lv) cmp(e.req, "loc_rdata", loc_rdata, e.ld);
      if (e.chk_da) cmp(e.req, "dev_addr", dev_addr, e.da);
      if (e.chk_rw) cmp(e.req, "ram_wdata", ram_wdata, e.rw);
      if (e.chk_cw) cmp(e.req, "color_wdata", color_wdata, e.cw);
      cmp(e.req, "exp_trig", exp_trig, e.trig);
    end
  end

  task automatic io_dev(input logic [15:0] a, input logic isrd, inout exp_t e);
    case (a[11:8])
      4'h0, 4'h1, 4'h2, 4'h3: begin e.sel[S_VID] = 1; e.chk_da = 1; e.da = {4'd0, a[5:0]}; end
      4'h4, 4'h5, 4'h6, 4'h7: begin e.sel[S_SND] = 1; e.chk_da = 1; e.da = {5'd0, a[4:0]}; end
      4'h8, 4'h9, 4'hA, 4'hB: begin
        e.sel[S_COL] = 1; e.chk_da = 1; e.da = a[9:0];
        if (isrd) begin e.lv = 1; e.ld = {vbus_byte[7:4], color_q}; end
        else begin e.chk_cw = 1; e.cw = wdata[3:0]; end
      end
      4'hC: begin e.sel[S_T1] = 1; e.chk_da = 1; e.da = {6'd0, a[3:0]}; end
      4'hD: begin e.sel[S_T2] = 1; e.chk_da = 1; e.da = {6'd0, a[3:0]}; end
      default: begin
        if (a[15:4] == 12'hDF0) begin e.sel[S_EXP] = 1; e.chk_da = 1; e.da = {6'd0, a[3:0]}; end
        else if (isrd && a < 16'hDFA0) begin e.lv = 1; e.ld = vbus_byte; end
        else if (isrd) begin
          e.lv = 1;
          if (a == 16'hDFFF) begin m_id = ~m_id; e.ld = m_id; end
          else e.ld = 8'h00;
        end
      end
    endcase
  endtask

  task automatic access(input logic [15:0] a, input logic r, input logic w,
                        input logic [7:0] d, input string req);
    exp_t e;
    logic [7:0] p;
    logic io, chr;
    @(posedge clk); #1;
    addr = a; rd = r; wr = w; wdata = d;
    e.sel = '0; e.lv = 0; e.ld = 0; e.chk_da = 0; e.da = 0; e.chk_rw = 0; e.rw = 0;
    e.chk_cw = 0; e.cw = 0; e.trig = 0; e.req = req;
    p = ~m_dir | m_dat;
    io = (p[1:0] != 2'b00) && p[2];
    chr = (p[1:0] != 2'b00) && !p[2];
    if (w) begin
      if (a[15:12] == 4'hD && io) io_dev(a, 1'b0, e);
      else begin
        e.sel[S_RAM] = 1; e.chk_rw = 1;
        e.rw = (a < 16'd2) ? vbus_byte : d;
        e.trig = (a == 16'hFF00);
      end
    end else if (r) begin
      if (a < 16'd2) begin
        e.lv = 1;
        e.ld = a[0] ? ((m_dir & m_dat) | (~m_dir & 8'h17)) : m_dir;
      end else if (a[15:12] == 4'hA || a[15:12] == 4'hB) begin
        if (p[1:0] == 2'b11) e.sel[S_BAS] = 1; else e.sel[S_RAM] = 1;
      end else if (a[15:12] >= 4'hE) begin
        if (p[1]) e.sel[S_KRM] = 1; else e.sel[S_RAM] = 1;
      end else if (a[15:12] == 4'hD) begin
        if (io) io_dev(a, 1'b1, e);
        else if (chr) e.sel[S_CHR] = 1;
        else e.sel[S_RAM] = 1;
      end else e.sel[S_RAM] = 1;
    end
    q.push_back(e);
    if (w && a == 16'd0) m_dir = d;
    if (w && a == 16'd1) m_dat = d;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    access(16'h0000, 1, 0, 0, "R1");
    access(16'h0001, 1, 0, 0, "R1");
    access(16'hA123, 1, 0, 0, "R4");
    access(16'hE456, 1, 0, 0, "R5");
    access(16'h1234, 1, 0, 0, "R11");
    access(16'hD021, 1, 0, 0, "R7");
    access(16'hD4F8, 1, 0, 0, "R7");
    access(16'hDBFF, 1, 0, 0, "R8");
    access(16'hDC0E, 1, 0, 0, "R7");
    access(16'hDD35, 1, 0, 0, "R7");
    access(16'hDF03, 1, 0, 0, "R7");
    access(16'hDE10, 1, 0, 0, "R9");
    access(16'hDFA5, 1, 0, 0, "R9");
    access(16'hDFFF, 1, 0, 0, "R10");
    access(16'hDFFF, 1, 0, 0, "R10");
    access(16'hDFFF, 1, 0, 0, "R10");
    access(16'hFF00, 0, 1, 8'h9A, "R11");
    access(16'hE000, 0, 1, 8'h11, "R11");
    access(16'hA000, 0, 1, 8'h22, "R11");
    access(16'hD020, 0, 1, 8'h0E, "R7");
    access(16'hD805, 0, 1, 8'hF6, "R8");
    access(16'hDE40, 0, 1, 8'h77, "R9");
    access(16'hDF0A, 0, 1, 8'h01, "R7");
    access(16'h0000, 0, 1, 8'h07, "R3");
    access(16'h0001, 0, 1, 8'h06, "R3");
    access(16'h0000, 1, 0, 0, "R2");
    access(16'h0001, 1, 0, 0, "R2");
    access(16'hA000, 1, 0, 0, "R4");
    access(16'hE000, 1, 0, 0, "R5");
    access(16'h0001, 0, 1, 8'h05, "R2");
    access(16'hE000, 1, 0, 0, "R5");
    access(16'hD400, 1, 0, 0, "R6");
    access(16'h0001, 0, 1, 8'h01, "R2");
    access(16'hD000, 1, 0, 0, "R6");
    access(16'hD000, 0, 1, 8'h44, "R11");
    access(16'h0001, 0, 1, 8'h00, "R2");
    access(16'hD000, 1, 0, 0, "R6");
    access(16'hDFFF, 1, 0, 0, "R6");
    access(16'h0001, 1, 0, 0, "R2");
    access(16'hFF00, 0, 0, 0, "R12");
    access(16'h0001, 0, 1, 8'h07, "R2");
    access(16'hDFFF, 1, 0, 0, "R10");
    @(posedge clk); #1 rd = 0; wr = 0;
    repeat (3) @(posedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule